// File: doc/BRIEF.md
# Redundant Trip Channel Voter

This block is the decision and actuation core of a two-channel safety shutdown function. Each channel has a sample strobe and a data word, which come from an upstream sensor path. A channel copies each accepted sample into its own holding register, so both channels present settled values to the vote. A per-channel update watchdog counts the clock cycles since the last accepted sample. If no sample arrives before a programmable limit, the watchdog loads an all-ones backup value. That value lies at or above any threshold, so a silent sensor pushes the function toward shutdown.

The vote is one-out-of-two: either channel at or above the trip level sets a sticky trip. The trip closes two independent valves. Shutdown counts as achieved once either valve reports closed. The trip stays set until software pulses a reset input while both channels read below the level. A scheduler in the block periodically asks both valves to close for a short window, as a proof test. Position feedback is watched during proof tests and during real trips. A valve that stays open for a fixed number of commanded cycles is flagged as faulty. Each channel reports a two-bit health state.

Top module: `trip_voter`

## Requirements
- R1: After reset, valve_close_cmd is 00, trip_active is 0, valve_fault is 00, both ch_state fields are 00 (healthy), and each watchdog starts at age zero with a held value of zero.
- R2: A strobe in a cycle where the channel's age has not reached wd_limit loads smp_data into that channel's register and restarts the age at zero.
- R3: A channel whose age equals wd_limit at a clock edge loads the all-ones backup value, marks itself lost and restarts its age at zero. Lost means ch_state 11 until the next accepted strobe.
- R4: A strobe that arrives in the same cycle as a watchdog expiry is ignored: the backup value and lost state win.
- R5: Once either held value is greater than or equal to trip_level, trip_active is 1 from the next clock edge.
- R6: While trip_active is 1 or a proof test is running, both bits of valve_close_cmd are 1. Otherwise both are 0.
- R7: trip_active stays 1 until trip_reset is high in a cycle where both held values are below trip_level. It clears at that edge.
- R8: While untripped, a proof test starts every PERIOD cycles and commands the valves closed for WAIT cycles. The period count is held at zero while tripped or testing.
- R9: valve_fault[i] sets when valve i is commanded closed and reads open (valve_closed[i]=0) for WAIT consecutive cycles. trip_reset clears it.
- R10: Each ch_state field is encoded 11 = lost, else 10 = valve fault on the same-index valve, else 01 = value at or above trip_level, else 00 = healthy. Channel 0 uses bits [1:0].
- R11: shutdown_ok is 1 exactly when trip_active is 1 and at least one valve_closed bit is 1.

Ports use DW=8 and TW=8 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 2 | Per-channel sample strobe |
| smp_data | input | 2 x DW | Per-channel sample word |
| trip_level | input | DW | Trip threshold, inclusive |
| wd_limit | input | TW | Watchdog limit in cycles |
| trip_reset | input | 1 | Request to clear the trip and the valve faults |
| valve_closed | input | 2 | Valve position feedback, 1 = closed |
| valve_close_cmd | output | 2 | Close command per valve |
| trip_active | output | 1 | Sticky trip flag |
| valve_fault | output | 2 | Sticky valve-did-not-close flags |
| ch_state | output | 2 x 2 | Per-channel health code |
| shutdown_ok | output | 1 | Trip present and at least one valve closed |

## Verification
A wrong channel register or watchdog age shows up on ch_state and trip_active within one or two cycles. It appears at the next expiry or strobe, or when the held value crosses the level. A wrong proof-test or valve counter surfaces only when a test window opens or closes. That can be up to PERIOD cycles later, so the bench runs several full periods with both healthy and stuck valves. The reference model is compared on every cycle. Any divergence in a sticky flag is therefore reported at the first cycle it differs, not only when a scenario ends.

// File: rtl/trip_pkg.sv
package trip_pkg;
    typedef enum logic [1:0] {
        ST_HEALTHY = 2'b00,
        ST_DEMAND  = 2'b01,
        ST_DANGER  = 2'b10,
        ST_LOST    = 2'b11
    } chan_state_t;
endpackage

// File: rtl/trip_channel.sv
module trip_channel #(
    parameter int DW = 8,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stb,
    input  logic [DW-1:0] data,
    input  logic [TW-1:0] limit,
    output logic [DW-1:0] value,
    output logic          lost
);
    typedef struct packed {
        logic [DW-1:0] held;
        logic          lost;
        logic [TW-1:0] age;
    } chan_regs_t;

    chan_regs_t st_d, st_q;
    logic expire;

    always_comb begin
        st_d   = st_q;
        expire = (st_q.age == limit);
        if (expire) begin
            st_d.held = '1;
            st_d.lost = 1'b1;
            st_d.age  = '0;
        end else if (stb) begin
            st_d.held = data;
            st_d.lost = 1'b0;
            st_d.age  = '0;
        end else begin
            st_d.age  = st_q.age + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.held;
    assign lost  = st_q.lost;

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && st_q.age != limit) |=> (!st_q.lost && st_q.held == $past(data)));
    assert_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.age == limit) |=> (st_q.lost && st_q.held == '1 && st_q.age == '0));
    assert_late_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && st_q.age == limit) |=> st_q.lost);
endmodule

// File: rtl/valve_watch.sv
module valve_watch #(
    parameter int WAIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic closed,
    input  logic clr,
    output logic fault
);
    localparam int WCW = $clog2(WAIT + 1);

    typedef struct packed {
        logic [WCW-1:0] cnt;
        logic           fault;
    } vw_regs_t;

    vw_regs_t st_d, st_q;
    logic open_cmd, limit_hit;

    always_comb begin
        st_d      = st_q;
        open_cmd  = cmd && !closed;
        limit_hit = open_cmd && (st_q.cnt == WCW'(WAIT - 1));
        if (!open_cmd)      st_d.cnt = '0;
        else if (!limit_hit) st_d.cnt = st_q.cnt + 1'b1;
        if (clr)            st_d.fault = 1'b0;
        else if (limit_hit) st_d.fault = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault = st_q.fault;

    assert_fault_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd && !closed && st_q.cnt == WCW'(WAIT - 1) && !clr) |=> fault);
    assert_fault_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !fault);
endmodule

// File: rtl/proof_sched.sv
module proof_sched #(
    parameter int PERIOD = 64,
    parameter int WAIT   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic testing
);
    localparam int PCW = $clog2(PERIOD + 1);
    localparam int TCW = $clog2(WAIT + 1);

    typedef struct packed {
        logic [PCW-1:0] pcnt;
        logic [TCW-1:0] tcnt;
        logic           on;
    } ps_regs_t;

    ps_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.on) begin
            if (st_q.tcnt == TCW'(WAIT - 1)) begin
                st_d.on   = 1'b0;
                st_d.tcnt = '0;
            end else begin
                st_d.tcnt = st_q.tcnt + 1'b1;
            end
        end
        if (hold || st_q.on) begin
            st_d.pcnt = '0;
        end else if (st_q.pcnt == PCW'(PERIOD - 1)) begin
            st_d.pcnt = '0;
            st_d.on   = 1'b1;
            st_d.tcnt = '0;
        end else begin
            st_d.pcnt = st_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign testing = st_q.on;

    assert_no_start_in_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !st_q.on) |=> !st_q.on);
endmodule

// File: rtl/trip_voter.sv
module trip_voter
    import trip_pkg::*;
#(
    parameter int DW     = 8,
    parameter int TW     = 8,
    parameter int WAIT   = 4,
    parameter int PERIOD = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          smp_stb,
    input  logic [1:0][DW-1:0]  smp_data,
    input  logic [DW-1:0]       trip_level,
    input  logic [TW-1:0]       wd_limit,
    input  logic                trip_reset,
    input  logic [1:0]          valve_closed,
    output logic [1:0]          valve_close_cmd,
    output logic                trip_active,
    output logic [1:0]          valve_fault,
    output logic [1:0][1:0]     ch_state,
    output logic                shutdown_ok
);
    localparam int NCH = 2;

    typedef struct packed {
        logic trip;
    } vote_regs_t;

    vote_regs_t st_d, st_q;

    logic [NCH-1:0][DW-1:0] held;
    logic [NCH-1:0]         lost;
    logic [NCH-1:0]         demand;
    logic [NCH-1:0]         vfault;
    logic                   testing;
    logic                   close_all;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        trip_channel #(.DW(DW), .TW(TW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (smp_stb[i]),
            .data  (smp_data[i]),
            .limit (wd_limit),
            .value (held[i]),
            .lost  (lost[i])
        );
        assign demand[i] = (held[i] >= trip_level);

        valve_watch #(.WAIT(WAIT)) u_valve (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd    (close_all),
            .closed (valve_closed[i]),
            .clr    (trip_reset),
            .fault  (vfault[i])
        );
    end

    proof_sched #(.PERIOD(PERIOD), .WAIT(WAIT)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (st_q.trip),
        .testing (testing)
    );

    always_comb begin
        st_d = st_q;
        if (|demand)         st_d.trip = 1'b1;
        else if (trip_reset) st_d.trip = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            if (lost[i])        ch_state[i] = ST_LOST;
            else if (vfault[i]) ch_state[i] = ST_DANGER;
            else if (demand[i]) ch_state[i] = ST_DEMAND;
            else                ch_state[i] = ST_HEALTHY;
        end
    end

    assign close_all       = st_q.trip | testing;
    assign valve_close_cmd = {NCH{close_all}};
    assign trip_active     = st_q.trip;
    assign valve_fault     = vfault;
    assign shutdown_ok     = st_q.trip & (|valve_closed);

    assert_vote_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|demand) |=> trip_active);
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_active && !trip_reset) |=> trip_active);
    assert_close_on_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trip_active |-> (valve_close_cmd == 2'b11));
    assert_shutdown_R11: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_ok |-> (trip_active && valve_closed != 2'b00));
endmodule

// File: tb/sim_trip_voter.sv
module sim_trip_voter;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8, TW = 8, WAIT = 4, PERIOD = 64;
    localparam int BACKUP = 255;

    logic clk = 0, rst_n = 0;
    logic [1:0] smp_stb = 0;
    logic [1:0][DW-1:0] smp_data = '0;
    logic [DW-1:0] trip_level = 8'd100;
    logic [TW-1:0] wd_limit = 8'd10;
    logic trip_reset = 0;
    logic [1:0] valve_closed = 0;
    logic [1:0] valve_close_cmd, valve_fault;
    logic trip_active, shutdown_ok;
    logic [1:0][1:0] ch_state;

    trip_voter #(.DW(DW), .TW(TW), .WAIT(WAIT), .PERIOD(PERIOD)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .trip_level(trip_level), .wd_limit(wd_limit), .trip_reset(trip_reset),
        .valve_closed(valve_closed), .valve_close_cmd(valve_close_cmd),
        .trip_active(trip_active), .valve_fault(valve_fault),
        .ch_state(ch_state), .shutdown_ok(shutdown_ok));

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // stimulus sources for the channels
    bit [1:0] gen_en = 0, force_stb = 0, stuck = 0;
    int gen_per[2] = '{5, 7};
    int gen_cnt[2] = '{0, 0};
    int gen_dat[2] = '{10, 20};
    int force_dat[2] = '{0, 0};
    bit cmd_h1[2], cmd_h2[2];

    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (force_stb[i]) begin
                smp_stb[i]  <= 1'b1;
                smp_data[i] <= force_dat[i][DW-1:0];
            end else if (gen_en[i] && gen_cnt[i] == 0) begin
                smp_stb[i]  <= 1'b1;
                smp_data[i] <= gen_dat[i][DW-1:0];
            end else begin
                smp_stb[i]  <= 1'b0;
            end
            gen_cnt[i] <= (gen_cnt[i] + 1) % gen_per[i];
            // plant valve: closes two cycles after the command
            cmd_h2[i] <= cmd_h1[i];
            cmd_h1[i] <= valve_close_cmd[i];
            valve_closed[i] <= cmd_h2[i] && !stuck[i];
        end
    end

    // behavioural reference model
    int m_val[2], m_age[2], m_wc[2];
    bit m_lost[2], m_flt[2];
    bit m_trip, m_test;
    int m_tc, m_pc;

    function automatic bit above(int i);
        return m_val[i] >= int'(trip_level);
    endfunction

    initial begin
        m_val = '{0, 0}; m_age = '{0, 0}; m_wc = '{0, 0};
        m_lost = '{0, 0}; m_flt = '{0, 0};
        m_trip = 0; m_test = 0; m_tc = 0; m_pc = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_val = '{0, 0}; m_age = '{0, 0}; m_wc = '{0, 0};
            m_lost = '{0, 0}; m_flt = '{0, 0};
            m_trip = 0; m_test = 0; m_tc = 0; m_pc = 0;
        end else begin
            bit dem, cmd, n_trip, n_test;
            int n_tc, n_pc;
            dem = above(0) || above(1);
            cmd = m_trip || m_test;
            for (int i = 0; i < 2; i++) begin
                if (m_age[i] == int'(wd_limit)) begin
                    m_val[i] = BACKUP; m_lost[i] = 1; m_age[i] = 0;
                end else if (smp_stb[i]) begin
                    m_val[i] = int'(smp_data[i]); m_lost[i] = 0; m_age[i] = 0;
                end else m_age[i]++;
                if (cmd && !valve_closed[i]) begin
                    if (m_wc[i] == WAIT - 1) begin
                        if (!trip_reset) m_flt[i] = 1;
                    end else m_wc[i]++;
                end else m_wc[i] = 0;
                if (trip_reset) m_flt[i] = 0;
            end
            n_trip = dem ? 1'b1 : (trip_reset ? 1'b0 : m_trip);
            n_test = m_test; n_tc = m_tc; n_pc = m_pc;
            if (m_test) begin
                if (m_tc == WAIT - 1) begin n_test = 0; n_tc = 0; end
                else n_tc = m_tc + 1;
            end
            if (m_trip || m_test) n_pc = 0;
            else if (m_pc == PERIOD - 1) begin n_pc = 0; n_test = 1; n_tc = 0; end
            else n_pc = m_pc + 1;
            m_trip = n_trip; m_test = n_test; m_tc = n_tc; m_pc = n_pc;
        end
    end

    function automatic int exp_state(int i);
        if (m_lost[i]) return 3;
        if (m_flt[i]) return 2;
        if (above(i)) return 1;
        return 0;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R5/R7 trip_active", trip_active, m_trip);
            chk("R6/R8 valve_close_cmd", valve_close_cmd, (m_trip || m_test) ? 3 : 0);
            chk("R9 valve_fault", valve_fault, {m_flt[1], m_flt[0]});
            chk("R2/R3/R4/R10 ch_state0", ch_state[0], exp_state(0));
            chk("R2/R3/R4/R10 ch_state1", ch_state[1], exp_state(1));
            chk("R11 shutdown_ok", shutdown_ok, (m_trip && valve_closed != 0) ? 1 : 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<200000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse_reset();
        trip_reset = 1; tick(); trip_reset = 0;
    endtask

    initial begin
        tick(3);
        // R1: reset state
        chk("R1 valve_close_cmd", valve_close_cmd, 0);
        chk("R1 trip_active", trip_active, 0);
        chk("R1 valve_fault", valve_fault, 0);
        chk("R1 ch_state", ch_state, 0);
        rst_n = 1;
        gen_en = 2'b11;
        // R2, R8: healthy running across several proof tests
        tick(200);
        chk("R8 no trip during healthy run", trip_active, 0);
        chk("R9 healthy valves no fault", valve_fault, 0);

        // R5: channel 0 crosses the level, exactly at the boundary
        gen_dat[0] = 100;
        tick(12);
        chk("R5 trip on equal-to-level", trip_active, 1);
        chk("R10 demand state ch0", ch_state[0], 1);
        // R7: reset refused while above level
        pulse_reset(); tick(2);
        chk("R7 trip held while demand", trip_active, 1);
        gen_dat[0] = 99;
        tick(12);
        chk("R7 still sticky before reset", trip_active, 1);
        pulse_reset(); tick(1);
        chk("R7 cleared by reset", trip_active, 0);

        // R3/R4: channel 1 goes silent, late strobe lands on expiry
        tick(30);
        gen_en[1] = 0;
        while (!(m_age[1] == int'(wd_limit))) tick();
        force_dat[1] = 5; force_stb[1] = 1;
        tick(); force_stb[1] = 0;
        tick();
        chk("R4 late strobe ignored -> lost", ch_state[1], 3);
        chk("R3 backup value forces trip", trip_active, 1);
        gen_en[1] = 1;
        tick(12);
        chk("R2 recovered channel healthy", ch_state[1], 0);
        pulse_reset(); tick(2);
        chk("R7 cleared after recovery", trip_active, 0);

        // R9: stuck valve 1 under a real trip
        stuck[1] = 1;
        gen_dat[0] = 200;
        tick(20);
        chk("R9 stuck valve flagged", valve_fault, 2'b10);
        chk("R10 danger state ch1", ch_state[1], 2);
        chk("R11 shutdown with one valve", shutdown_ok, 1);
        gen_dat[0] = 30; stuck[1] = 0;
        tick(12);
        pulse_reset(); tick(3);
        chk("R9 fault cleared", valve_fault, 0);

        // R8/R9: stuck valve 0 caught by the proof test alone
        stuck[0] = 1;
        tick(PERIOD + 2 * WAIT + 4);
        chk("R9 proof test finds stuck valve", valve_fault[0], 1);
        chk("R8 proof test does not trip", trip_active, 0);
        stuck[0] = 0;
        pulse_reset();
        // R10: threshold change alone moves states and trips
        trip_level = 8'd15;
        tick(20);
        chk("R10 demand after level drop", ch_state[1], 1);
        trip_level = 8'd100;
        tick(20);
        pulse_reset(); tick(5);
        chk("R7 final clear", trip_active, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule